// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This block is the interrupt front end of a UART. It turns two FIFO fill levels and five event pulses into a set of sticky status bits. The fill-level sources are receive data waiting and transmit space available. The pulse sources are receive timeout, framing error, parity error, break and overrun. Each status bit stays set until software acknowledges it. An enable mask selects which status bits may reach the single interrupt line. The interrupt line is the OR of the enabled status bits.

The two fill-level events come from comparing each FIFO's fill count against a threshold. Each threshold is a programmable fraction of the FIFO depth, chosen by a 3-bit code. The receive event fires when enough data has arrived. The transmit event fires when the transmit FIFO has drained far enough. A small register port gives access to the threshold codes, the mask, the raw status, the masked status and a write-one-to-clear acknowledge register. Reads are combinational. Writes take effect at the next clock edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted, raw status and mask read as 0, the threshold register reads 0x12 (both codes set to 2), and `irq` is low, regardless of the fill and event inputs.
- R2: The threshold register is at offset 0. Bits [5:3] hold the receive code and bits [2:0] hold the transmit code. A write stores wdata[5:0], and a read returns the value last stored.
- R3: Threshold codes 0, 1, 2, 3 and 4 select 1/8, 2/8, 4/8, 6/8 and 7/8 of DEPTH (2, 4, 8, 12 and 14 entries for DEPTH=16). Codes 5, 6 and 7 act as code 4.
- R4: Raw bit 4 is set at a clock edge where `rx_fill` is greater than or equal to the receive threshold. The threshold is taken from the code stored before that edge.
- R5: Raw bit 5 is set at a clock edge where `tx_fill` is less than or equal to the transmit threshold.
- R6: Raw bits 6 to 10 are set by `ev_rx_timeout`, `ev_frame_err`, `ev_parity_err`, `ev_break_err` and `ev_overrun`, in that order. Raw bits stay set until they are cleared. Raw status reads at offset 2.
- R7: The mask register is at offset 1 and is 11 bits wide. The masked status reads at offset 3 and equals raw AND mask.
- R8: `irq` is high exactly when the masked status is non-zero.
- R9: A write to offset 4 clears the raw bits that are 1 in wdata[10:0] at that edge. Bits written as 0 are left unchanged.
- R10: When a bit is set and cleared at the same edge, it ends up set.
- R11: Raw bits 0 to 3 always read 0. Writes to offsets 2, 3, 5, 6 and 7 change no register.
- R12: Reads of offsets 4 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| rx_fill | input | $clog2(DEPTH+1) | Receive FIFO fill count |
| tx_fill | input | $clog2(DEPTH+1) | Transmit FIFO fill count |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_break_err | input | 1 | Break condition pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: DEPTH=16 and DATA_W=16. With DEPTH=16, every threshold (2, 4, 8, 12 and 14) lies inside the fill range 0 to 16. This lets the bench drive each code with fills one step below, at, and one step above its threshold, and also with completely full and completely empty FIFOs. Because DATA_W=16 is wider than the 11 status bits, the bench can also confirm that the unused upper read bits stay zero.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int STAT_W = 11;
  localparam int ADDR_W = 3;
  localparam int CODE_W = 3;

  localparam logic [ADDR_W-1:0] ADR_LVL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_RAW   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MSTAT = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CLR   = 3'd4;

  localparam int BIT_RXLVL = 4;
  localparam int BIT_TXLVL = 5;
  localparam int BIT_TMO   = 6;
  localparam int BIT_FRM   = 7;
  localparam int BIT_PAR   = 8;
  localparam int BIT_BRK   = 9;
  localparam int BIT_OVR   = 10;

  localparam logic [2*CODE_W-1:0] LVL_RST = 6'b010_010;

  // Fill fraction in eighths of the FIFO depth for a threshold code.
  function automatic int thr_eighths(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/uirq_level_cmp.sv
module uirq_level_cmp
  import uirq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter bit IS_RX  = 1'b1,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic [CODE_W-1:0] code,
  input  logic [FILL_W-1:0] fill,
  output logic              hit
);
  localparam int STEP = DEPTH / 8;

  logic [FILL_W-1:0] thr;
  int                thr_full;

  always_comb begin
    thr_full = STEP * thr_eighths(code);
    thr      = thr_full[FILL_W-1:0];
  end

  generate
    if (IS_RX) begin : g_rx
      assign hit = (fill >= thr);
    end else begin : g_tx
      assign hit = (fill <= thr);
    end
  endgenerate
endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
  parameter int STAT_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set,
  input  logic [STAT_W-1:0] clr,
  output logic [STAT_W-1:0] raw_q
);
  logic [STAT_W-1:0] raw_d;
  logic              raw_en;

  always_comb begin
    raw_en = |(set | clr);
    raw_d  = (raw_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end
endmodule

// File: rtl/uirq_regif.sv
module uirq_regif
  import uirq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [STAT_W-1:0]     raw,
  output logic [DATA_W-1:0]     rdata,
  output logic [2*CODE_W-1:0]   lvl_q,
  output logic [STAT_W-1:0]     mask_q,
  output logic [STAT_W-1:0]     clr
);
  logic [2*CODE_W-1:0] lvl_d;
  logic [STAT_W-1:0]   mask_d;
  logic                lvl_en;
  logic                mask_en;
  logic                unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:STAT_W];

  always_comb begin
    lvl_d   = lvl_q;
    mask_d  = mask_q;
    lvl_en  = 1'b0;
    mask_en = 1'b0;
    clr     = '0;
    if (wr_en) begin
      case (addr)
        ADR_LVL: begin
          lvl_en = 1'b1;
          lvl_d  = wdata[2*CODE_W-1:0];
        end
        ADR_MASK: begin
          mask_en = 1'b1;
          mask_d  = wdata[STAT_W-1:0];
        end
        ADR_CLR: clr = wdata[STAT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= LVL_RST;
      mask_q <= '0;
    end else begin
      if (lvl_en)  lvl_q  <= lvl_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_LVL:   rdata[2*CODE_W-1:0] = lvl_q;
      ADR_MASK:  rdata[STAT_W-1:0]   = mask_q;
      ADR_RAW:   rdata[STAT_W-1:0]   = raw;
      ADR_MSTAT: rdata[STAT_W-1:0]   = raw & mask_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_fill,
  input  logic              ev_rx_timeout,
  input  logic              ev_frame_err,
  input  logic              ev_parity_err,
  input  logic              ev_break_err,
  input  logic              ev_overrun,
  output logic              irq
);
  logic [2*CODE_W-1:0] lvl_q;
  logic [STAT_W-1:0]   mask_q;
  logic [STAT_W-1:0]   raw_q;
  logic [STAT_W-1:0]   clr;
  logic [STAT_W-1:0]   set;
  logic                rx_hit;
  logic                tx_hit;

  uirq_level_cmp #(.DEPTH(DEPTH), .IS_RX(1'b1), .FILL_W(FILL_W)) u_rx_cmp (
    .code (lvl_q[2*CODE_W-1:CODE_W]),
    .fill (rx_fill),
    .hit  (rx_hit)
  );

  uirq_level_cmp #(.DEPTH(DEPTH), .IS_RX(1'b0), .FILL_W(FILL_W)) u_tx_cmp (
    .code (lvl_q[CODE_W-1:0]),
    .fill (tx_fill),
    .hit  (tx_hit)
  );

  always_comb begin
    set            = '0;
    set[BIT_RXLVL] = rx_hit;
    set[BIT_TXLVL] = tx_hit;
    set[BIT_TMO]   = ev_rx_timeout;
    set[BIT_FRM]   = ev_frame_err;
    set[BIT_PAR]   = ev_parity_err;
    set[BIT_BRK]   = ev_break_err;
    set[BIT_OVR]   = ev_overrun;
  end

  uirq_status #(.STAT_W(STAT_W)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set),
    .clr   (clr),
    .raw_q (raw_q)
  );

  uirq_regif #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .raw    (raw_q),
    .rdata  (rdata),
    .lvl_q  (lvl_q),
    .mask_q (mask_q),
    .clr    (clr)
  );

  assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk
  import uirq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [FILL_W-1:0] rx_fill,
  input logic [FILL_W-1:0] tx_fill,
  input logic              ev_frame_err,
  input logic              ev_overrun,
  input logic              irq,
  input logic [STAT_W-1:0] raw_q,
  input logic [STAT_W-1:0] mask_q
);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

  AST_RX_FULL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill == FULL) |=> raw_q[BIT_RXLVL]); // R4

  AST_TX_EMPTY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fill == '0) |=> raw_q[BIT_TXLVL]); // R5

  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADR_CLR) |=> (($past(raw_q) & ~raw_q) == '0)); // R6

  AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R8

  AST_W1C_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADR_CLR && wdata[BIT_FRM] && !ev_frame_err) |=> !raw_q[BIT_FRM]); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> raw_q[BIT_OVR]); // R10
endmodule

bind uart_irq_ctrl uirq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FILL_W(FILL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .addr         (addr),
  .wdata        (wdata),
  .rx_fill      (rx_fill),
  .tx_fill      (tx_fill),
  .ev_frame_err (ev_frame_err),
  .ev_overrun   (ev_overrun),
  .irq          (irq),
  .raw_q        (raw_q),
  .mask_q       (mask_q)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 16;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [2:0]        addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic [FILL_W-1:0] rx_fill;
  logic [FILL_W-1:0] tx_fill;
  logic              ev_rx_timeout, ev_frame_err, ev_parity_err, ev_break_err, ev_overrun;
  logic              irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [10:0] m_raw;
  logic [10:0] m_mask;
  logic [5:0]  m_lvl;

  uart_irq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rx_fill(rx_fill), .tx_fill(tx_fill),
    .ev_rx_timeout(ev_rx_timeout), .ev_frame_err(ev_frame_err),
    .ev_parity_err(ev_parity_err), .ev_break_err(ev_break_err),
    .ev_overrun(ev_overrun), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_thr(input logic [2:0] code);
    case (code)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      default: return 14;
    endcase
  endfunction

  function automatic logic [10:0] exp_set(input int rxf, input int txf,
                                          input logic [4:0] ev, input logic [5:0] lvl);
    logic [10:0] s;
    s       = '0;
    s[4]    = (rxf >= exp_thr(lvl[5:3]));
    s[5]    = (txf <= exp_thr(lvl[2:0]));
    s[10:6] = ev;
    return s;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic verify(input string tag);
    logic [15:0] v;
    rd(3'd2, v); chk(tag, "raw", v, {5'd0, m_raw});
    rd(3'd3, v); chk(tag, "masked", v, {5'd0, m_raw & m_mask});
    rd(3'd1, v); chk(tag, "mask", v, {5'd0, m_mask});
    rd(3'd0, v); chk(tag, "levels", v, {10'd0, m_lvl});
    chk(tag, "irq", {15'd0, irq}, {15'd0, |(m_raw & m_mask)});
  endtask

  // One clock: drive at negedge, update the model at the edge, check at next negedge.
  task automatic step(input string tag, input logic w, input logic [2:0] a,
                      input logic [15:0] d, input int rxf, input int txf,
                      input logic [4:0] ev);
    logic [10:0] clr;
    wr_en   = w;
    addr    = a;
    wdata   = d;
    rx_fill = FILL_W'(rxf);
    tx_fill = FILL_W'(txf);
    {ev_overrun, ev_break_err, ev_parity_err, ev_frame_err, ev_rx_timeout} = ev;
    @(posedge clk);
    clr   = (w && a == 3'd4) ? d[10:0] : 11'd0;
    m_raw = (m_raw & ~clr) | exp_set(rxf, txf, ev, m_lvl);
    if (w && a == 3'd0) m_lvl  = d[5:0];
    if (w && a == 3'd1) m_mask = d[10:0];
    @(negedge clk);
    wr_en = 1'b0;
    {ev_overrun, ev_break_err, ev_parity_err, ev_frame_err, ev_rx_timeout} = '0;
    verify(tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    rx_fill = FILL_W'(16); tx_fill = '0;
    {ev_overrun, ev_break_err, ev_parity_err, ev_frame_err, ev_rx_timeout} = 5'b11111;
    m_raw = '0; m_mask = '0; m_lvl = 6'h12;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state holds despite active sources
    rd(3'd2, v); chk("R1", "raw in reset", v, 16'h0);
    rd(3'd1, v); chk("R1", "mask in reset", v, 16'h0);
    rd(3'd0, v); chk("R1", "levels in reset", v, 16'h0012);
    chk("R1", "irq in reset", {15'd0, irq}, 16'h0);
    {ev_overrun, ev_break_err, ev_parity_err, ev_frame_err, ev_rx_timeout} = '0;
    rx_fill = '0; tx_fill = FILL_W'(16);
    rst_n = 1'b1;
    @(negedge clk);
    verify("R1");

    // R2/R3/R4: receive threshold sweep over all codes
    for (int c = 0; c < 8; c++) begin
      step("R2", 1'b1, 3'd0, 16'((c << 3) | 7), 0, 16, '0);
      step("R9", 1'b1, 3'd4, 16'h07ff, 0, 16, '0);
      step("R3", 1'b0, 3'd0, '0, exp_thr(3'(c)) - 1, 16, '0);
      step("R4", 1'b0, 3'd0, '0, exp_thr(3'(c)), 16, '0);
    end
    // R3/R5: transmit threshold sweep
    for (int c = 0; c < 8; c++) begin
      step("R2", 1'b1, 3'd0, 16'((7 << 3) | c), 0, 16, '0);
      step("R9", 1'b1, 3'd4, 16'h07ff, 0, 16, '0);
      step("R3", 1'b0, 3'd0, '0, 0, exp_thr(3'(c)) + 1, '0);
      step("R5", 1'b0, 3'd0, '0, 0, exp_thr(3'(c)), '0);
    end
    step("R9", 1'b1, 3'd4, 16'h07ff, 0, 16, '0);

    // R6: each event pulse, sticky afterwards
    for (int b = 0; b < 5; b++) step("R6", 1'b0, 3'd0, '0, 0, 16, 5'(1 << b));
    step("R6", 1'b0, 3'd0, '0, 0, 16, '0);
    // R7/R8: mask writes
    step("R7", 1'b1, 3'd1, 16'h0540, 0, 16, '0);
    step("R8", 1'b1, 3'd1, 16'h0000, 0, 16, '0);
    step("R8", 1'b1, 3'd1, 16'h0080, 0, 16, '0);
    // R9: partial clear of frame and break
    step("R9", 1'b1, 3'd4, 16'h0280, 0, 16, '0);
    // R10: overrun set and cleared together
    step("R10", 1'b1, 3'd4, 16'h07ff, 0, 16, 5'b10000);
    // R11: writes to read-only and unmapped offsets
    step("R11", 1'b1, 3'd2, 16'hffff, 0, 16, '0);
    step("R11", 1'b1, 3'd3, 16'hffff, 0, 16, '0);
    step("R11", 1'b1, 3'd6, 16'hffff, 0, 16, '0);
    // R12: reads of offsets 4..7
    for (int a = 4; a < 8; a++) begin
      rd(3'(a), v);
      chk("R12", "unmapped read", v, 16'h0);
    end

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic        w;
      logic [2:0]  a;
      logic [15:0] d;
      logic [4:0]  ev;
      w  = ($urandom_range(2, 0) == 0);
      a  = 3'($urandom_range(7, 0));
      d  = 16'($urandom());
      ev = ($urandom_range(3, 0) == 0) ? 5'($urandom_range(31, 0)) : 5'd0;
      step("R6", w, a, d, int'($urandom_range(16, 0)), int'($urandom_range(16, 0)), ev);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule